// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of an asynchronous parallel flash device. It takes one request at a time from a local valid/ready interface: write one byte, erase one sector, or erase the whole array. For each request it plays out the fixed unlock-and-command write sequence on the flash bus. Every write cycle is built from three timed phases: setup, write-enable low, and recovery.

Once the last command write is done, the block polls the target address with output-enable reads. It watches bit 7 of the returned data until that bit shows completion. It then reports the result as a one-cycle done pulse with an error flag. The error flag is raised when the polling window runs past a per-operation cycle budget.

All strobe timings and both time budgets are parameters counted in system clock cycles. The same logic therefore serves any clock rate and any speed grade of the flash part.

Top module: `flash_cmd_seq`

## Requirements
- R1: Out of reset, chip select, write enable and output enable are all high, the data bus is not driven, `reqReady` is high and `doneValid` is low.
- R2: A program request (`reqOp` = 0) produces exactly four write cycles:
  - AAh at address 555h,
  - 55h at 2AAh,
  - A0h at 555h,
  - the request data byte at the request address.
- R3: A sector erase request (`reqOp` = 1) produces six write cycles:
  - AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh,
  - then 30h at the request address.
- R4: A chip erase request (`reqOp` = 2) produces the same first five writes as R3, with a sixth write of 10h at 555h.
- R5: In every write cycle, address and data are driven for `SETUP_CYC` cycles before write enable falls. Write enable then stays low for exactly `PULSE_CYC` cycles. Address and data stay unchanged until `RECOV_CYC` cycles after write enable rises. Between pulses of one request, write enable is high for `SETUP_CYC + RECOV_CYC` cycles.
- R6: The data bus is driven only during write cycles. Output enable is never low while write enable is low or while the data bus is driven. Chip select is low whenever either strobe is low.
- R7: After the last write, the block polls the request address:
  - Output enable is low for `READ_CYC` cycles per read, and is high for `GAP_CYC` cycles between reads.
  - Bit 7 is sampled on the last low cycle of each read.
  - A program completes when bit 7 equals bit 7 of the programmed byte. An erase completes when bit 7 reads 1.
- R8: The poll timer starts when polling starts. If a read finishes without completion and the timer has reached `PROG_TMO_CYC` (program) or `ERASE_TMO_CYC` (erase), the request ends with `doneErr` = 1.
- R9: A request is accepted in a cycle where `reqValid` and `reqReady` are both high. `reqReady` stays low from acceptance until the done pulse. `doneValid` is high for exactly one cycle, with `doneErr` = 0 on success, and `reqReady` returns the cycle after it.
- R10: `reqOp` = 3 is treated as a chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqOp | input | 2 | 0 program, 1 sector erase, 2 or 3 chip erase |
| reqAddr | input | ADDR_W | Byte or sector address of the request |
| reqData | input | 8 | Byte to program |
| doneValid | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Completion timed out (valid with doneValid) |
| flashAddr | output | ADDR_W | Flash address bus |
| flashDqOut | output | 8 | Data driven toward the flash |
| flashDqOe | output | 1 | Enable for the data bus drivers |
| flashDq7In | input | 1 | Bit 7 of the flash data bus as read back |
| flashCsN | output | 1 | Active-low chip select |
| flashWeN | output | 1 | Active-low write enable |
| flashOeN | output | 1 | Active-low output enable |

## Verification
The bench builds the block with setup 2, pulse 3, recovery 2, read 2 and gap 1 cycles. Each phase therefore spans several cycles, so widths and hold intervals are measured rather than collapsing to a single cycle. Budgets of 40 cycles for program and 60 for erase replace the real multi-second limits. This puts both timeout paths within a few dozen polls: the 14th read for program and the 21st for erase. The polling model answers "busy" for a chosen number of reads, which exercises both immediate and delayed completion for each polarity of bit 7.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
  localparam logic [7:0] CMD_ERASE    = 8'h80;
  localparam logic [7:0] CMD_SECTOR   = 8'h30;
  localparam logic [7:0] CMD_CHIP     = 8'h10;

  localparam logic [11:0] ADR_UNLOCK_A = 12'h555;
  localparam logic [11:0] ADR_UNLOCK_B = 12'h2AA;

  typedef enum logic [2:0] {
    S_IDLE, S_WSETUP, S_WPULSE, S_WRECOV, S_RLOW, S_RGAP, S_DONE
  } seqState_e;

  typedef enum logic [2:0] {
    PH_SETUP, PH_PULSE, PH_RECOV, PH_READ, PH_GAP
  } phase_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic   capture;
    logic   cntLoad;
    phase_e cntSel;
    logic   stepInc;
    logic   tmoClr;
    logic   tmoRun;
    logic   readAddr;
  } dpCtrl_t;

endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int SETUP_CYC     = 1,
  parameter int PULSE_CYC     = 3,
  parameter int RECOV_CYC     = 1,
  parameter int READ_CYC      = 5,
  parameter int GAP_CYC       = 1,
  parameter int PROG_TMO_CYC  = 15000,
  parameter int ERASE_TMO_CYC = 400000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic              dq7In,
  output logic              phDone,
  output logic              lastStep,
  output logic              tmoHit,
  output logic              pollOk,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busData
);

  localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_B   = (RECOV_CYC > READ_CYC) ? RECOV_CYC : READ_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int PH_MAX  = (MAX_C > GAP_CYC) ? MAX_C : GAP_CYC;
  localparam int CNT_W   = $clog2(PH_MAX + 1);
  localparam int TMO_MAX = (PROG_TMO_CYC > ERASE_TMO_CYC) ? PROG_TMO_CYC : ERASE_TMO_CYC;
  localparam int TMO_W   = $clog2(TMO_MAX + 1);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(ADR_UNLOCK_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(ADR_UNLOCK_B);

  logic [ADDR_W-1:0] tgtAddr;
  logic [7:0]        tgtData;
  logic              isErase;
  logic              isChip;
  logic [2:0]        step;
  logic [CNT_W-1:0]  phCnt;
  logic [CNT_W-1:0]  loadVal;
  logic [TMO_W-1:0]  tmoCnt;
  logic [ADDR_W-1:0] romAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtAddr <= '0;
      tgtData <= '0;
      isErase <= 1'b0;
      isChip  <= 1'b0;
    end else if (ctl.capture) begin
      tgtAddr <= reqAddr;
      tgtData <= reqData;
      isErase <= |reqOp;
      isChip  <= reqOp[1];
    end
  end

  always_comb begin
    case (ctl.cntSel)
      PH_SETUP: loadVal = CNT_W'(SETUP_CYC - 1);
      PH_PULSE: loadVal = CNT_W'(PULSE_CYC - 1);
      PH_RECOV: loadVal = CNT_W'(RECOV_CYC - 1);
      PH_READ:  loadVal = CNT_W'(READ_CYC - 1);
      default:  loadVal = CNT_W'(GAP_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                phCnt <= '0;
    else if (ctl.cntLoad)     phCnt <= loadVal;
    else if (phCnt != '0)     phCnt <= phCnt - 1'b1;
  end
  assign phDone = (phCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)             step <= '0;
    else if (ctl.capture)  step <= '0;
    else if (ctl.stepInc)  step <= step + 3'd1;
  end
  assign lastStep = (step == (isErase ? 3'd5 : 3'd3));

  always_ff @(posedge clk) begin
    if (!rstN)                               tmoCnt <= '0;
    else if (ctl.tmoClr)                     tmoCnt <= '0;
    else if (ctl.tmoRun && (tmoCnt != '1))   tmoCnt <= tmoCnt + 1'b1;
  end
  assign tmoHit = isErase ? (tmoCnt >= TMO_W'(ERASE_TMO_CYC))
                          : (tmoCnt >= TMO_W'(PROG_TMO_CYC));
  assign pollOk = isErase ? dq7In : (dq7In == tgtData[7]);

  // Command sequence table
  always_comb begin
    romAddr = ADR_A;
    busData = CMD_UNLOCK_A;
    case (step)
      3'd0: begin romAddr = ADR_A; busData = CMD_UNLOCK_A; end
      3'd1: begin romAddr = ADR_B; busData = CMD_UNLOCK_B; end
      3'd2: begin romAddr = ADR_A; busData = isErase ? CMD_ERASE : CMD_PROGRAM; end
      3'd3: begin
        romAddr = isErase ? ADR_A : tgtAddr;
        busData = isErase ? CMD_UNLOCK_A : tgtData;
      end
      3'd4: begin romAddr = ADR_B; busData = CMD_UNLOCK_B; end
      default: begin
        romAddr = isChip ? ADR_A : tgtAddr;
        busData = isChip ? CMD_CHIP : CMD_SECTOR;
      end
    endcase
  end

  assign busAddr = ctl.readAddr ? tgtAddr : romAddr;

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    phDone,
  input  logic    lastStep,
  input  logic    tmoHit,
  input  logic    pollOk,
  output logic    reqReady,
  output logic    doneValid,
  output logic    doneErr,
  output logic    csN,
  output logic    weN,
  output logic    oeN,
  output logic    dqOe,
  output dpCtrl_t ctl
);

  seqState_e state, nextState;
  logic      errQ;

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      S_IDLE: if (reqValid) begin
        ctl.capture = 1'b1;
        ctl.cntLoad = 1'b1;
        ctl.cntSel  = PH_SETUP;
        nextState   = S_WSETUP;
      end
      S_WSETUP: if (phDone) begin
        ctl.cntLoad = 1'b1;
        ctl.cntSel  = PH_PULSE;
        nextState   = S_WPULSE;
      end
      S_WPULSE: if (phDone) begin
        ctl.cntLoad = 1'b1;
        ctl.cntSel  = PH_RECOV;
        nextState   = S_WRECOV;
      end
      S_WRECOV: if (phDone) begin
        ctl.cntLoad = 1'b1;
        if (lastStep) begin
          ctl.tmoClr = 1'b1;
          ctl.cntSel = PH_READ;
          nextState  = S_RLOW;
        end else begin
          ctl.stepInc = 1'b1;
          ctl.cntSel  = PH_SETUP;
          nextState   = S_WSETUP;
        end
      end
      S_RLOW: begin
        ctl.tmoRun   = 1'b1;
        ctl.readAddr = 1'b1;
        if (phDone) begin
          if (pollOk || tmoHit) begin
            nextState = S_DONE;
          end else begin
            ctl.cntLoad = 1'b1;
            ctl.cntSel  = PH_GAP;
            nextState   = S_RGAP;
          end
        end
      end
      S_RGAP: begin
        ctl.tmoRun   = 1'b1;
        ctl.readAddr = 1'b1;
        if (phDone) begin
          ctl.cntLoad = 1'b1;
          ctl.cntSel  = PH_READ;
          nextState   = S_RLOW;
        end
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_RLOW && phDone) errQ <= !pollOk;
    end
  end

  assign reqReady  = (state == S_IDLE);
  assign doneValid = (state == S_DONE);
  assign doneErr   = (state == S_DONE) && errQ;
  assign csN       = (state == S_IDLE) || (state == S_DONE);
  assign weN       = (state != S_WPULSE);
  assign oeN       = (state != S_RLOW);
  assign dqOe      = (state == S_WSETUP) || (state == S_WPULSE) || (state == S_WRECOV);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int SETUP_CYC     = 1,
  parameter int PULSE_CYC     = 3,
  parameter int RECOV_CYC     = 1,
  parameter int READ_CYC      = 5,
  parameter int GAP_CYC       = 1,
  parameter int PROG_TMO_CYC  = 15000,
  parameter int ERASE_TMO_CYC = 400000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  output logic              doneValid,
  output logic              doneErr,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashDqOut,
  output logic              flashDqOe,
  input  logic              flashDq7In,
  output logic              flashCsN,
  output logic              flashWeN,
  output logic              flashOeN
);

  dpCtrl_t ctl;
  logic    phDone, lastStep, tmoHit, pollOk;

  flash_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .phDone(phDone), .lastStep(lastStep), .tmoHit(tmoHit), .pollOk(pollOk),
    .reqReady(reqReady), .doneValid(doneValid), .doneErr(doneErr),
    .csN(flashCsN), .weN(flashWeN), .oeN(flashOeN), .dqOe(flashDqOe),
    .ctl(ctl)
  );

  flash_seq_dp #(
    .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .RECOV_CYC(RECOV_CYC), .READ_CYC(READ_CYC), .GAP_CYC(GAP_CYC),
    .PROG_TMO_CYC(PROG_TMO_CYC), .ERASE_TMO_CYC(ERASE_TMO_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData), .dq7In(flashDq7In),
    .phDone(phDone), .lastStep(lastStep), .tmoHit(tmoHit), .pollOk(pollOk),
    .busAddr(flashAddr), .busData(flashDqOut)
  );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W    = 20,
  parameter int PULSE_CYC = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              doneValid,
  input logic [ADDR_W-1:0] flashAddr,
  input logic [7:0]        flashDqOut,
  input logic              flashDqOe,
  input logic              flashCsN,
  input logic              flashWeN,
  input logic              flashOeN
);

  localparam int CW = $clog2(PULSE_CYC + 2) + 1;
  logic [CW-1:0] weLowCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                                 weLowCnt <= '0;
    else if (flashWeN)                         weLowCnt <= '0;
    else if (weLowCnt != '1)                   weLowCnt <= weLowCnt + 1'b1;
  end

  assert_we_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWeN) |-> (weLowCnt == CW'(PULSE_CYC)));

  assert_setup_before_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashWeN) |-> ($past(flashDqOe) && $stable(flashAddr) && $stable(flashDqOut)));

  assert_hold_while_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN && !$past(flashWeN)) |-> ($stable(flashAddr) && $stable(flashDqOut)));

  assert_hold_after_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWeN) |-> (flashDqOe && $stable(flashAddr) && $stable(flashDqOut)));

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rstN)
    !flashOeN |-> (flashWeN && !flashDqOe));

  assert_cs_framing_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN || !flashOeN) |-> !flashCsN);

  assert_read_addr_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!flashOeN && !$past(flashOeN)) |-> $stable(flashAddr));

  assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (flashCsN && flashWeN && flashOeN && !flashDqOe));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .doneValid(doneValid),
  .flashAddr(flashAddr), .flashDqOut(flashDqOut), .flashDqOe(flashDqOe),
  .flashCsN(flashCsN), .flashWeN(flashWeN), .flashOeN(flashOeN)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

  localparam int AW = 20;
  localparam int SU = 2;
  localparam int PW = 3;
  localparam int RC = 2;
  localparam int RD = 2;
  localparam int GP = 1;
  localparam int PTMO = 40;
  localparam int ETMO = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic reqReady, doneValid, doneErr;
  logic [AW-1:0] flashAddr;
  logic [7:0] flashDqOut;
  logic flashDqOe, flashCsN, flashWeN, flashOeN;
  logic flashDq7In;

  always #10 clk = ~clk;  // 50 MHz

  flash_cmd_seq #(
    .ADDR_W(AW), .SETUP_CYC(SU), .PULSE_CYC(PW), .RECOV_CYC(RC),
    .READ_CYC(RD), .GAP_CYC(GP), .PROG_TMO_CYC(PTMO), .ERASE_TMO_CYC(ETMO)
  ) u_flash_cmd_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
    .doneValid(doneValid), .doneErr(doneErr),
    .flashAddr(flashAddr), .flashDqOut(flashDqOut), .flashDqOe(flashDqOe),
    .flashDq7In(flashDq7In), .flashCsN(flashCsN), .flashWeN(flashWeN),
    .flashOeN(flashOeN)
  );

  int checks = 0;
  int errors = 0;

  // scoreboard queues
  logic [AW+7:0] wrQ[$];
  bit            errQ[$];
  int            readsQ[$];

  // driver -> model settings
  int            nextBusy = 0;
  logic          nextExp = 1'b0;
  logic [AW-1:0] nextTgt = '0;

  // monitor / flash model state
  int            doneCount = 0;
  int            busyLeft = 0;
  logic          modelBusy = 1'b0;
  logic          modelExp = 1'b0;
  logic [AW-1:0] curTgt = '0;
  int            readsSeen = 0;
  int            pulseIdx = 0;
  int            weLow = 0, weHigh = 0, oeLow = 0, oeHigh = 0;
  logic [AW-1:0] latchA = '0;
  logic [7:0]    latchD = '0;
  logic          prevWe = 1'b1, prevOe = 1'b1, prevReady = 1'b1, prevDone = 1'b0;

  assign flashDq7In = modelBusy ? ~modelExp : modelExp;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor and flash model, sampling on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (prevReady && !reqReady) begin
        readsSeen = 0;
        pulseIdx  = 0;
        busyLeft  = nextBusy;
        modelExp  = nextExp;
        curTgt    = nextTgt;
      end
      // R6: contention and framing
      if (!flashOeN) begin
        chk(flashWeN && !flashDqOe && !flashCsN, "R6", "oe low with we/drive",
            {flashWeN, flashDqOe, flashCsN}, 3'b100);
        chk(flashAddr == curTgt, "R7", "poll address", flashAddr, curTgt);
      end
      // write strobe tracking
      if (!flashWeN) begin
        if (prevWe) begin
          latchA = flashAddr;
          latchD = flashDqOut;
          chk(flashDqOe, "R6", "bus driven at we fall", flashDqOe, 1);
          if (pulseIdx > 0) chk(weHigh == SU + RC, "R5", "we high between pulses", weHigh, SU + RC);
          pulseIdx++;
          weLow = 1;
        end else begin
          weLow++;
          chk(flashAddr == latchA && flashDqOut == latchD, "R5", "addr/data move during pulse",
              {flashAddr, flashDqOut}, {latchA, latchD});
        end
      end else begin
        if (!prevWe) begin
          chk(weLow == PW, "R5", "we low width", weLow, PW);
          chk(flashDqOe && flashAddr == latchA && flashDqOut == latchD, "R5", "hold after rise",
              {flashAddr, flashDqOut}, {latchA, latchD});
          if (wrQ.size() == 0) begin
            chk(1'b0, "R2", "unexpected write", {latchA, latchD}, 0);
          end else begin
            logic [AW+7:0] e;
            e = wrQ.pop_front();
            chk({latchA, latchD} == e, "R2 R3 R4 R10", "write cycle addr/data", {latchA, latchD}, e);
          end
          weHigh = 1;
        end else begin
          weHigh++;
        end
      end
      // read strobe tracking and flash model
      if (!flashOeN) begin
        if (prevOe) begin
          readsSeen++;
          if (readsSeen > 1) chk(oeHigh == GP, "R7", "oe gap between reads", oeHigh, GP);
          if (busyLeft > 0) begin
            modelBusy = 1'b1;
            busyLeft--;
          end else begin
            modelBusy = 1'b0;
          end
          oeLow = 1;
        end else begin
          oeLow++;
        end
      end else begin
        if (!prevOe) begin
          chk(oeLow == RD, "R7", "oe low width", oeLow, RD);
          oeHigh = 1;
        end else begin
          oeHigh++;
        end
      end
      // completion
      if (doneValid) begin
        if (errQ.size() == 0) begin
          chk(1'b0, "R9", "unexpected done", 1, 0);
        end else begin
          bit   ee;
          int   er;
          ee = errQ.pop_front();
          er = readsQ.pop_front();
          chk(doneErr == ee, "R8 R9", "done error flag", doneErr, ee);
          chk(readsSeen == er, "R7 R8", "poll read count", readsSeen, er);
          chk(wrQ.size() == 0, "R2 R3 R4", "missing writes", wrQ.size(), 0);
        end
        doneCount++;
      end
      if (prevDone) chk(!doneValid, "R9", "done longer than one cycle", doneValid, 0);
      prevWe    = flashWeN;
      prevOe    = flashOeN;
      prevReady = reqReady;
      prevDone  = doneValid;
    end
  end

  task automatic doReq(input logic [1:0] op, input logic [AW-1:0] addr, input logic [7:0] data,
                       input int busy, input bit expErr, input int expReads);
    bit isE;
    int base;
    logic [AW-1:0] a555, a2aa;
    a555 = AW'(12'h555);
    a2aa = AW'(12'h2AA);
    isE  = (op != 2'd0);
    wrQ.push_back({a555, 8'hAA});
    wrQ.push_back({a2aa, 8'h55});
    if (!isE) begin
      wrQ.push_back({a555, 8'hA0});
      wrQ.push_back({addr, data});
    end else begin
      wrQ.push_back({a555, 8'h80});
      wrQ.push_back({a555, 8'hAA});
      wrQ.push_back({a2aa, 8'h55});
      if (op[1]) wrQ.push_back({a555, 8'h10});
      else       wrQ.push_back({addr, 8'h30});
    end
    errQ.push_back(expErr);
    readsQ.push_back(expReads);
    nextBusy = busy;
    nextExp  = isE ? 1'b1 : data[7];
    nextTgt  = addr;
    base     = doneCount;
    @(negedge clk);
    reqOp    = op;
    reqAddr  = addr;
    reqData  = data;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R9", "ready low after accept", reqReady, 0);
    while (doneCount == base) @(negedge clk);
    @(negedge clk);
    chk(reqReady, "R9", "ready back after done", reqReady, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: idle state during and after reset
    chk(flashCsN && flashWeN && flashOeN && !flashDqOe && reqReady && !doneValid, "R1",
        "reset outputs", {flashCsN, flashWeN, flashOeN, flashDqOe, reqReady, doneValid}, 6'b111010);
    rstN = 1'b1;
    @(negedge clk);
    chk(flashCsN && flashWeN && flashOeN && !flashDqOe && reqReady, "R1", "idle outputs",
        {flashCsN, flashWeN, flashOeN, flashDqOe, reqReady}, 5'b11101);

    doReq(2'd0, 20'h12345, 8'hC3, 3, 1'b0, 4);     // R2 R7 program, bit7=1, delayed
    doReq(2'd0, 20'h0ABCD, 8'h3C, 0, 1'b0, 1);     // R2 R7 program, bit7=0, immediate
    doReq(2'd1, 20'h50000, 8'h00, 2, 1'b0, 3);     // R3 sector erase
    doReq(2'd2, 20'h00777, 8'h00, 1, 1'b0, 2);     // R4 chip erase
    doReq(2'd3, 20'h00123, 8'h00, 0, 1'b0, 1);     // R10 code 3 acts as chip erase
    doReq(2'd0, 20'hFFFFF, 8'h81, 1000, 1'b1, 14); // R8 program timeout
    doReq(2'd1, 20'h30000, 8'h00, 1000, 1'b1, 21); // R8 erase timeout
    doReq(2'd0, 20'h00001, 8'h7F, 2, 1'b0, 3);     // R9 recovers after timeout

    repeat (3) @(negedge clk);
    chk(flashCsN && flashWeN && flashOeN && !flashDqOe, "R1", "quiet when idle",
        {flashCsN, flashWeN, flashOeN, flashDqOe}, 4'b1110);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule